// File: doc/BRIEF.md
# Validated Configuration and Read-Pointer Register Set

This block is the register set that a host sees behind a serial slave interface. The interface decoder in front of it hands over decoded instructions, each with a data byte. The block holds four configuration bits that drive the line-timing engine: active pullup, presence masking, strong pullup and speed. A configuration write is accepted only when its upper nibble is the bitwise inverse of its lower nibble, so a corrupted transfer cannot change the line mode.

Every host read returns one byte. That byte comes from one of three sources: the configuration register, the live status byte, or the live read-data byte. The source is not chosen by an address. It is chosen by a read pointer, and the pointer is set by whichever instruction was executed last. A device-reset strobe clears the configuration and points at status. A pulse from the timing engine marks the end of a strong pullup and clears the strong-pullup bit.

Top module: `cfg_ptr_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, all four configuration outputs are 0 and `rd_byte` follows `stat_in`.
- R2: A configuration write (`cmd_op`=0) with `cmd_data[7:4]` == ~`cmd_data[3:0]` loads the lower nibble on the next clock. The bit map is bit0 = active pullup, bit1 = presence masking, bit2 = strong pullup, bit3 = speed.
- R3: A configuration write whose upper nibble is not the inverse of its lower nibble leaves all four configuration outputs unchanged.
- R4: When the pointer selects configuration, `rd_byte[7:4]` is 0 and `rd_byte[3:0]` holds the configuration bits.
- R5: `dev_rst` clears all configuration bits and points the read pointer at status on the next clock. It overrides any instruction in the same cycle.
- R6: A `spu_done` pulse clears the strong-pullup bit and keeps active pullup, presence masking and speed.
- R7: When `spu_done` coincides with a valid configuration write, the written value is kept, including its strong-pullup bit.
- R8: A set-pointer instruction (`cmd_op`=1) with data 8'h5A selects configuration, 8'hA5 selects status and 8'h3C selects read data. Any other data byte leaves the pointer unchanged.
- R9: Any configuration write, valid or not, points at configuration. A line-function instruction (`cmd_op`=2) points at status. A byte-read instruction (`cmd_op`=3) points at read data.
- R10: `rd_byte` follows the selected live input (`stat_in` or `rdat_in`) in the same cycle.
- R11: Nothing changes on a clock where `cmd_valid`, `dev_rst` and `spu_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_rst | input | 1 | Device-reset strobe, one cycle |
| cmd_valid | input | 1 | Decoded instruction present |
| cmd_op | input | 2 | 0 config write, 1 set pointer, 2 line function, 3 byte read |
| cmd_data | input | 8 | Instruction data byte |
| spu_done | input | 1 | Strong pullup has ended, one-cycle pulse |
| stat_in | input | 8 | Live status byte |
| rdat_in | input | 8 | Live read-data byte |
| cfg_apu | output | 1 | Active pullup enable |
| cfg_ppm | output | 1 | Presence masking enable |
| cfg_spu | output | 1 | Strong pullup armed |
| cfg_speed | output | 1 | High-speed line timing |
| rd_byte | output | 8 | Byte returned to a host read |

## Verification
The assertions assume that `dev_rst`, `cmd_valid` and `spu_done` are synchronous to `clk` and stable around each edge. They also assume that a strong-pullup rise can come only from a configuration write. The stimulus drives every input a fixed delay after the rising edge. It mixes directed corner cases with random instruction streams, among them coinciding strobes and writes with good and corrupted check nibbles. A behavioural model in the bench is compared against every output on each falling edge.

// File: rtl/cfg_ptr_regs.sv
module cfg_ptr_regs #(
  parameter logic [7:0] CODE_CFG  = 8'h5A,
  parameter logic [7:0] CODE_STAT = 8'hA5,
  parameter logic [7:0] CODE_DATA = 8'h3C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       spu_done,
  input  logic [7:0] stat_in,
  input  logic [7:0] rdat_in,
  output logic       cfg_apu,
  output logic       cfg_ppm,
  output logic       cfg_spu,
  output logic       cfg_speed,
  output logic [7:0] rd_byte
);
  localparam logic [1:0] P_CFG = 2'd0, P_STAT = 2'd1, P_DATA = 2'd2;
  localparam logic [1:0] OP_WCFG = 2'd0, OP_SRP = 2'd1, OP_LINE = 2'd2, OP_RBYTE = 2'd3;

  logic [3:0] cfg_q;
  logic [1:0] ptr_q;

  wire is_wcfg   = cmd_valid && cmd_op == OP_WCFG;
  wire cfg_ok    = cmd_data[7:4] == ~cmd_data[3:0];
  wire good_wcfg = is_wcfg && cfg_ok;

  logic [1:0] srp_target;
  logic       srp_hit;
  always_comb begin
    srp_hit    = 1'b1;
    srp_target = ptr_q;
    if (cmd_data == CODE_CFG)       srp_target = P_CFG;
    else if (cmd_data == CODE_STAT) srp_target = P_STAT;
    else if (cmd_data == CODE_DATA) srp_target = P_DATA;
    else                            srp_hit = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= 4'h0;
      ptr_q <= P_STAT;
    end else if (dev_rst) begin
      cfg_q <= 4'h0;
      ptr_q <= P_STAT;
    end else begin
      if (good_wcfg)      cfg_q    <= cmd_data[3:0];
      else if (spu_done)  cfg_q[2] <= 1'b0;
      if (cmd_valid) begin
        case (cmd_op)
          OP_WCFG:  ptr_q <= P_CFG;
          OP_SRP:   if (srp_hit) ptr_q <= srp_target;
          OP_LINE:  ptr_q <= P_STAT;
          default:  ptr_q <= P_DATA;
        endcase
      end
    end
  end

  assign cfg_apu   = cfg_q[0];
  assign cfg_ppm   = cfg_q[1];
  assign cfg_spu   = cfg_q[2];
  assign cfg_speed = cfg_q[3];
  assign rd_byte   = (ptr_q == P_CFG)  ? {4'h0, cfg_q} :
                     (ptr_q == P_STAT) ? stat_in : rdat_in;
endmodule

// File: rtl/cfg_ptr_regs_chk.sv
module cfg_ptr_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       spu_done,
  input logic [7:0] stat_in,
  input logic [7:0] rdat_in,
  input logic       cfg_apu,
  input logic       cfg_ppm,
  input logic       cfg_spu,
  input logic       cfg_speed,
  input logic [7:0] rd_byte
);
  wire [3:0] cfg = {cfg_speed, cfg_spu, cfg_ppm, cfg_apu};
  wire wcfg = cmd_valid && cmd_op == 2'd0;
  wire ok   = cmd_data[7:4] == ~cmd_data[3:0];

  AST_GOOD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wcfg && ok && !dev_rst) |=> cfg == $past(cmd_data[3:0])); // R2
  AST_BAD_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wcfg && !ok && !dev_rst && !spu_done) |=> $stable(cfg)); // R3
  AST_CFG_READ_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (wcfg && !dev_rst) |=> rd_byte[7:4] == 4'h0); // R4
  AST_DEVRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> (cfg == 4'h0 && rd_byte == stat_in)); // R5
  AST_SPU_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (spu_done && !(wcfg && ok) && !dev_rst) |=> !cfg_spu); // R6
  AST_SPU_DONE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (spu_done && !wcfg && !dev_rst) |=> (cfg_apu == $past(cfg_apu) && cfg_ppm == $past(cfg_ppm) && cfg_speed == $past(cfg_speed))); // R6
  AST_WRITE_BEATS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (spu_done && wcfg && ok && !dev_rst) |=> cfg_spu == $past(cmd_data[2])); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !dev_rst && !spu_done) |=> $stable(cfg)); // R11
  AST_SPU_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_spu) |-> $past(wcfg && ok)); // R2
endmodule

bind cfg_ptr_regs cfg_ptr_regs_chk u_chk (.*);

// File: tb/sim_cfg_ptr_regs.sv
module sim_cfg_ptr_regs;
  logic clk = 0, rst_n = 0, dev_rst = 0, cmd_valid = 0, spu_done = 0;
  logic [1:0] cmd_op = 0;
  logic [7:0] cmd_data = 0, stat_in = 8'h11, rdat_in = 8'h22;
  logic cfg_apu, cfg_ppm, cfg_spu, cfg_speed;
  logic [7:0] rd_byte;

  cfg_ptr_regs u0 (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int mcfg = 0, mptr = 1;
  string tag = "R1";
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin mcfg = 0; mptr = 1; end
    else if (dev_rst) begin mcfg = 0; mptr = 1; end
    else begin
      if (cmd_valid && cmd_op == 0 && ((cmd_data >> 4) == ((~cmd_data) & 15))) mcfg = cmd_data & 15;
      else if (spu_done) mcfg = mcfg & 11;
      if (cmd_valid) begin
        if (cmd_op == 0) mptr = 0;
        else if (cmd_op == 2) mptr = 1;
        else if (cmd_op == 3) mptr = 2;
        else if (cmd_data == 8'h5A) mptr = 0;
        else if (cmd_data == 8'hA5) mptr = 1;
        else if (cmd_data == 8'h3C) mptr = 2;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    int exp_rd;
    cyc++;
    exp_rd = (mptr == 0) ? mcfg : (mptr == 1) ? int'(stat_in) : int'(rdat_in);
    check(tag, {cfg_speed, cfg_spu, cfg_ppm, cfg_apu}, mcfg);
    check(tag, rd_byte, exp_rd);
  end

  task automatic step(bit v, logic [1:0] op, logic [7:0] d, bit dr, bit sd);
    @(posedge clk); #2;
    cmd_valid = v; cmd_op = op; cmd_data = d; dev_rst = dr; spu_done = sd;
    stat_in = stat_in + 8'd7; rdat_in = rdat_in ^ 8'h5F;
  endtask

  task automatic idle(); step(0, 0, 8'h00, 0, 0); endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tag = "R1"; repeat (3) @(posedge clk); #2; rst_n = 1; idle(); idle();
    tag = "R2"; step(1, 0, 8'hA5, 0, 0); idle(); step(1, 0, 8'h69, 0, 0); idle();
    tag = "R4"; idle(); step(1, 0, 8'h0F, 0, 0); idle();
    tag = "R3"; step(1, 0, 8'hFF, 0, 0); idle(); step(1, 0, 8'h00, 0, 0); idle();
    step(1, 0, 8'hB5, 0, 0); idle();
    tag = "R6"; step(1, 0, 8'h0F, 0, 0); step(0, 0, 0, 0, 1); idle();
    tag = "R7"; step(1, 0, 8'h4B, 0, 1); idle(); step(1, 0, 8'hF0, 0, 1); idle();
    tag = "R5"; step(1, 0, 8'h0F, 0, 0); step(1, 0, 8'h1E, 1, 0); idle();
    tag = "R8"; step(1, 1, 8'h3C, 0, 0); idle(); step(1, 1, 8'h77, 0, 0); idle();
    step(1, 1, 8'h5A, 0, 0); idle(); step(1, 1, 8'hA5, 0, 0); idle(); step(1, 1, 8'h00, 0, 0); idle();
    tag = "R9"; step(1, 3, 8'h00, 0, 0); idle(); step(1, 0, 8'h12, 0, 0); idle(); step(1, 2, 8'h00, 0, 0); idle();
    tag = "R10"; step(1, 3, 8'h00, 0, 0); repeat (4) idle();
    tag = "R11"; step(1, 0, 8'h87, 0, 0); repeat (4) idle();
    tag = "R2_R3_R6_R8_mix";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d = 8'($urandom);
      if ($urandom % 3 == 0) d = {~d[3:0], d[3:0]};
      if ($urandom % 4 == 0) d = (($urandom % 2) == 0) ? 8'h5A : 8'h3C;
      step($urandom % 3 != 0, 2'($urandom), d, $urandom % 40 == 0, $urandom % 6 == 0);
    end
    idle(); idle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule